// File: doc/BRIEF.md
# Packed INT8 Dot-Product Accumulate Unit

This unit executes one custom vector instruction: a four-way signed byte dot product that accumulates into 32-bit destination lanes. On a start pulse it compares the 32-bit instruction word against a fixed match/mask pattern. The vector-mask select bit sits outside that pattern, so the masked and unmasked forms decode as the same instruction. It also checks that the selected element width is 8 bits.

When the instruction is legal, the unit walks destination indices from the start index up to one below a quarter of the vector length. It produces one result per clock. Each result is the old destination lane plus four sign-extended byte products taken from the two source operands. The sum wraps modulo 2^32. Each result leaves the unit with its own write-enable and index. When the masked form is used, lanes whose mask bit is clear are skipped. Completion is signalled with a single-cycle done pulse together with a request to clear the start index.

The source operands, the destination array and the mask arrive as packed vectors. The surrounding register file must hold them stable while `busy` is high.

Top module: `dot4_acc_unit`

## Requirements
- R1: A start is accepted only when `(insn & 32'hFC00707F) == 32'h8000005B`. Bit 25 (vm) may take either value. A start with a non-matching word produces no write, no busy and no done.
- R2: If `sew_is8` is 0 on an accepted start, `illegal` and `done` pulse together one cycle later. No write happens and `vstart_clr` stays low.
- R3: The output count is `vl/4` (integer division). Indices `vstart`, `vstart+1`, … `vl/4-1` are presented on `wr_idx` on consecutive cycles, starting the cycle after start.
- R4: The result for index i is `vd_in[i] + Σ(g=0..3) sext(vs2 byte 4i+g) * sext(vs1 byte 4i+g)`, wrapping modulo 2^32. Byte k lies at bits `8k+7:8k` and lane i at bits `32i+31:32i`.
- R5: When vm (bit 25) is 0, index i with `vmask[i]==0` still takes its cycle but `wr_en` stays low. When vm is 1, `vmask` has no effect.
- R6: `done` and `vstart_clr` pulse for exactly one cycle, on the cycle after the last index.
- R7: If `vstart >= vl/4` on a legal start, `done` and `vstart_clr` pulse on the cycle after start and no write occurs.
- R8: While `busy` is high, `start` and changes of `vstart` are ignored.
- R9: During and after reset, `busy`, `wr_en`, `done`, `illegal` and `vstart_clr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Issue request |
| insn | input | 32 | Instruction word |
| sew_is8 | input | 1 | Selected element width is 8 bits |
| vl | input | CW+2 | Vector length in bytes |
| vstart | input | CW | First destination index |
| vs2 | input | 32*NE | First source bytes, packed |
| vs1 | input | 32*NE | Second source bytes, packed |
| vd_in | input | 32*NE | Current destination lanes, packed |
| vmask | input | NE | Per-destination mask bits |
| busy | output | 1 | Iteration in progress |
| wr_en | output | 1 | Write this lane |
| wr_idx | output | EW | Lane index of the write |
| wr_data | output | 32 | Accumulated lane value |
| done | output | 1 | Completion pulse |
| illegal | output | 1 | Illegal-instruction pulse |
| vstart_clr | output | 1 | Request to write start index to 0 |

## Verification
The bench builds the unit with NE=4: four destination lanes, sixteen source bytes, a 5-bit length and a 3-bit start index. This brings the whole vl range 0..16 within reach of a full sweep. The sweep is crossed with every start index 0..5, both vm settings and several mask values. As a result, the empty-loop case, the single-lane case and the full-length case are all covered. The data sets include all -128 bytes over a near-maximum accumulator, which forces 32-bit wrap. Separate runs cover non-matching words, a non-byte element width, and a second start issued mid-loop.

// File: rtl/dot4_acc_unit.sv
module dot4_acc_unit #(
  parameter int NE = 8,
  localparam int EW = $clog2(NE),
  localparam int CW = $clog2(NE + 1),
  localparam int VLW = CW + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       insn,
  input  logic              sew_is8,
  input  logic [VLW-1:0]    vl,
  input  logic [CW-1:0]     vstart,
  input  logic [32*NE-1:0]  vs2,
  input  logic [32*NE-1:0]  vs1,
  input  logic [32*NE-1:0]  vd_in,
  input  logic [NE-1:0]     vmask,
  output logic              busy,
  output logic              wr_en,
  output logic [EW-1:0]     wr_idx,
  output logic [31:0]       wr_data,
  output logic              done,
  output logic              illegal,
  output logic              vstart_clr
);
  localparam logic [31:0] OP_MASK  = 32'hFC00707F;
  localparam logic [31:0] OP_MATCH = 32'h8000005B;

  logic [EW-1:0] idx;
  logic [CW-1:0] nout_q;
  logic          masked_q;
  logic signed [31:0] dot;

  wire          hit  = (insn & OP_MASK) == OP_MATCH;
  wire [CW-1:0] nout = vl[VLW-1:2];
  wire          last = CW'(idx) == nout_q - CW'(1);

  always_comb begin
    dot = '0;
    for (int g = 0; g < 4; g++) begin
      logic signed [7:0]  a, b;
      logic signed [15:0] p;
      a = vs2[(int'(idx) * 4 + g) * 8 +: 8];
      b = vs1[(int'(idx) * 4 + g) * 8 +: 8];
      p = a * b;
      dot = dot + 32'(p);
    end
  end

  assign wr_idx  = idx;
  assign wr_en   = busy && (!masked_q || vmask[idx]);
  assign wr_data = vd_in[int'(idx) * 32 +: 32] + dot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      idx        <= '0;
      nout_q     <= '0;
      masked_q   <= 1'b0;
      done       <= 1'b0;
      illegal    <= 1'b0;
      vstart_clr <= 1'b0;
    end else begin
      done       <= 1'b0;
      illegal    <= 1'b0;
      vstart_clr <= 1'b0;
      if (busy) begin
        if (last) begin
          busy       <= 1'b0;
          done       <= 1'b1;
          vstart_clr <= 1'b1;
        end else begin
          idx <= idx + EW'(1);
        end
      end else if (start && hit) begin
        if (!sew_is8) begin
          done    <= 1'b1;
          illegal <= 1'b1;
        end else if (vstart >= nout) begin
          done       <= 1'b1;
          vstart_clr <= 1'b1;
        end else begin
          busy     <= 1'b1;
          idx      <= vstart[EW-1:0];
          nout_q   <= nout;
          masked_q <= !insn[25];
        end
      end
    end
  end

  AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (CW'(wr_idx) < nout_q)); // R3
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $past(rst_n)) |-> (wr_idx == EW'($past(wr_idx) + EW'(1)))); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_CLR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    vstart_clr |-> (done && !illegal)); // R6
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (done && !busy && !wr_en)); // R2
  AST_NO_WR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_en); // R9
endmodule

// File: tb/dot4_acc_unit_tb.sv
module dot4_acc_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 4;
  localparam int NBY = 4 * NE;

  logic clk = 0, rst_n = 0, start = 0, sew_is8 = 1;
  logic [31:0] insn = '0;
  logic [4:0] vl = '0;
  logic [2:0] vstart = '0;
  logic [32*NE-1:0] vs2, vs1, vd_in;
  logic [NE-1:0] vmask = '0;
  logic busy, wr_en, done, illegal, vstart_clr;
  logic [1:0] wr_idx;
  logic [31:0] wr_data;

  int vectors = 0, miscompares = 0;
  logic signed [7:0] av [NBY];
  logic signed [7:0] bv [NBY];
  logic [31:0] dv [NE];

  localparam logic [31:0] INSN_UNM = 32'h8200005B | (32'h0A << 20) | (32'h05 << 15) | (32'h03 << 7);
  localparam logic [31:0] INSN_MSK = 32'h8000005B | (32'h11 << 20) | (32'h02 << 15) | (32'h1F << 7);

  always #(CLK_PERIOD/2) clk = ~clk;

  dot4_acc_unit #(.NE(NE)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .insn(insn), .sew_is8(sew_is8),
    .vl(vl), .vstart(vstart), .vs2(vs2), .vs1(vs1), .vd_in(vd_in), .vmask(vmask),
    .busy(busy), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .done(done), .illegal(illegal), .vstart_clr(vstart_clr));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fill(input int p);
    for (int k = 0; k < NBY; k++) begin
      case (p)
        0: begin av[k] = -8'sd128; bv[k] = -8'sd128; end
        1: begin av[k] = 8'(k * 73 + 29); bv[k] = 8'(k * 151 + 7); end
        2: begin av[k] = (k % 2) ? 8'sd127 : -8'sd128; bv[k] = (k % 3) ? -8'sd128 : 8'sd127; end
        default: begin av[k] = 8'(k * 5 - 40); bv[k] = 8'(200 - k * 17); end
      endcase
      vs2[8*k +: 8] = av[k];
      vs1[8*k +: 8] = bv[k];
    end
    for (int i = 0; i < NE; i++) begin
      case (p)
        0: dv[i] = 32'h7FFF_FFF0 + 32'(i);
        1: dv[i] = 32'(i) * 32'h0123_4567;
        2: dv[i] = 32'h8000_0000 - 32'(i);
        default: dv[i] = 32'hFFFF_FFFF - 32'(i * 3);
      endcase
      vd_in[32*i +: 32] = dv[i];
    end
  endtask

  function automatic logic [31:0] expv(input int i);
    logic signed [31:0] e;
    e = dv[i];
    for (int g = 0; g < 4; g++) e = e + av[4*i+g] * bv[4*i+g];
    return e;
  endfunction

  task automatic run_case(input logic [31:0] iw, input logic s8, input int l, input int vs,
                          input logic [NE-1:0] m, input bit restart);
    int nout;
    bit msk;
    nout = l / 4;
    msk = !iw[25];
    @(negedge clk);
    insn = iw; sew_is8 = s8; vl = 5'(l); vstart = 3'(vs); vmask = m; start = 1;
    @(negedge clk);
    if (restart) begin start = 1; vstart = 0; end else start = 0;
    if (!s8) begin
      chk("R2 illegal", 32'(illegal), 1);
      chk("R2 done", 32'(done), 1);
      chk("R2 no write/clr", {30'b0, wr_en, vstart_clr}, 0);
    end else if (vs >= nout) begin
      chk("R7 done", {30'b0, done, vstart_clr}, 32'b11);
      chk("R7 no write", {30'b0, wr_en, busy}, 0);
    end else begin
      for (int i = vs; i < nout; i++) begin
        bit en;
        en = !msk || m[i];
        chk("R5 wr_en", 32'(wr_en), 32'(en));
        chk("R3 busy/done", {30'b0, busy, done}, 32'b10);
        if (en) begin
          chk("R3 wr_idx", 32'(wr_idx), 32'(i));
          chk("R4 wr_data", wr_data, expv(i));
        end
        @(negedge clk);
        start = 0; vstart = 3'(vs);
      end
      chk("R6 done/clr", {29'b0, done, vstart_clr, busy}, 32'b110);
      chk("R6 no write", 32'(wr_en), 0);
    end
    start = 0;
    @(negedge clk);
    chk("R6 pulse", {28'b0, done, vstart_clr, illegal, busy}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    fill(1);
    repeat (3) @(negedge clk);
    chk("R9 reset outputs", {27'b0, busy, wr_en, done, illegal, vstart_clr}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R9 after reset", {27'b0, busy, wr_en, done, illegal, vstart_clr}, 0);

    foreach (av[p]) if (p < 4) begin
      fill(p);
      for (int vm = 0; vm < 2; vm++)
        for (int l = 0; l <= 16; l++)
          for (int vs = 0; vs <= 5; vs++)
            run_case(vm ? INSN_UNM : INSN_MSK, 1'b1, l, vs, 4'(l * 3 + vs + p), 1'b0);
    end

    fill(1);
    run_case(INSN_MSK, 1'b1, 16, 1, 4'b0101, 1'b1);
    run_case(INSN_UNM, 1'b1, 16, 0, 4'b0000, 1'b1);
    run_case(INSN_UNM, 1'b0, 16, 0, 4'b1111, 1'b0);
    run_case(INSN_MSK, 1'b0, 8, 3, 4'b0000, 1'b0);

    foreach (dv[j]) begin
      logic [31:0] bad;
      case (j)
        0: bad = INSN_UNM | 32'h0000_1000;
        1: bad = INSN_UNM ^ 32'h0400_0000;
        2: bad = INSN_UNM ^ 32'h0000_0001;
        default: bad = INSN_UNM ^ 32'h0000_0020;
      endcase
      @(negedge clk);
      insn = bad; sew_is8 = 1; vl = 16; vstart = 0; vmask = '1; start = 1;
      @(negedge clk);
      start = 0;
      for (int c = 0; c < 3; c++) begin
        chk("R1 non-match ignored", {28'b0, busy, wr_en, done, illegal}, 0);
        @(negedge clk);
      end
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule